// File: doc/BRIEF.md
# Two-Wire Bus Timing and Condition Generator

This block is the timing core of a two-wire serial master. A byte engine hands it one request at a time: a START condition, a STOP condition or a single bit slot. The block produces the open-drain pull-down enables for the clock line and the data line, and it raises a one-cycle done pulse when the request's last interval has run out. The system clock is fast compared with the bus, so every interval is a count of system clock cycles. Bus rates and minimum hold times are met by loading suitable counts. At a 50 MHz system clock, 500 cycles give a 100 kHz bus, 125 cycles give 400 kHz, and 30 cycles cover a 0.6 µs hold.

Four counts set the timing. The divider sets the bus clock period. It is split into a low half of `div/2` and a high half of the remainder. A start-hold count sets how long the clock stays high after the data line falls for a START. A stop-setup count sets how long the clock is high before the data line rises for a STOP. A data-hold count sets how long the data line stays put after each falling clock edge. The clock and data lines are read back through a resynchronizer of `SYNC_STAGES` flops. The high-phase count only begins once the clock line is seen high, so a slave that holds the clock low just lengthens the cycle. In a read slot, the data line level is captured at the end of the high phase.

Bit and STOP requests assume the clock line is already held low by an earlier START or bit. A START can be issued from an idle bus or as a repeated START after a bit.

Top module: `i2c_bus_timer`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, both pull-down enables are 0 (lines released), and done and busy are 0.
- R2: For a START, the data enable rises while the clock line is high. The clock enable then rises exactly `cfg_start_hold` cycles later. At the done pulse, both enables are 1.
- R3: For a STOP, the data enable falls exactly `cfg_stop_setup + SYNC_STAGES + 1` cycles after the clock line first reads high. Done follows `div - div/2` cycles after that fall, with both enables 0.
- R4: After a bit slot or a START pulls the clock enable high, done rises exactly `cfg_data_hold` cycles later, and the data enable does not change in between.
- R5: In a bit slot, the clock enable falls `div/2` cycles after the clock edge that accepts the request. It rises again `div - div/2 + SYNC_STAGES + 1` cycles after the clock line first reads high.
- R6: If a slave holds the clock line low after release, the high-phase count waits. The clock enable rises `div - div/2 + SYNC_STAGES + 1` cycles after the line finally reads high, whatever the length of the stretch.
- R7: done is high for exactly one cycle per request. busy is 0 in that cycle.
- R8: Requests are only accepted while busy is 0, and requests made while busy is 1 have no effect. When requests arrive together, START wins over STOP, and STOP wins over bit.
- R9: At the done pulse of a bit slot, rx_bit equals the data line level seen at the end of the clock high phase.
- R10: In a bit slot, the data enable changes only at the accepting edge, while the clock is held low. It is set to the inverse of bit_val, so 1 means pull low.
- R11: A count of 0 behaves like a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_scl_div | input | CNT_W | Bus clock period in system cycles (at least 2) |
| cfg_start_hold | input | CNT_W | Clock-high cycles after the data line falls for START |
| cfg_stop_setup | input | CNT_W | Clock-high cycles counted before the data line rises for STOP |
| cfg_data_hold | input | CNT_W | Cycles the data line is kept after the clock falls |
| req_start | input | 1 | Request a START (or a repeated START) |
| req_stop | input | 1 | Request a STOP |
| req_bit | input | 1 | Request one bit slot |
| bit_val | input | 1 | Bit to send; 1 releases the data line so a slave can drive it |
| scl_in | input | 1 | Clock line as read from the pad |
| sda_in | input | 1 | Data line as read from the pad |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| rx_bit | output | 1 | Data line level captured in the last bit slot |
| done | output | 1 | One-cycle pulse when a request finishes |
| busy | output | 1 | A request is in progress |

## Verification
The bench stretches the clock line for several cycles, and checks that the high time is measured from the moment the line reads high. A design that counted from its own release would cut the high phase short. It loads an odd divider, to catch a swapped or truncated low/high split. It loads zero hold counts, which a plain down-counter would wrap to its maximum. It also asserts START with a bit request, and STOP with a bit request, in the same cycle, and pulses a stray STOP in the middle of a bit slot. A broken priority or a missing busy guard would then leave the lines in the wrong state, or end the slot early with a second done pulse.

// File: rtl/i2c_tmr_pkg.sv
// Shared types for the two-wire bus timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_tmr_pkg;

    // Sequencer phases of one request.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_LOW,    // clock held low, low half counting
        ST_RISE,   // clock released, waiting to read it high
        ST_HIGH,   // clock seen high, high interval counting
        ST_MID,    // START only: data low, clock still high
        ST_TAIL    // final interval before done
    } tmr_state_e;

    // Kind of request in progress.
    typedef enum logic [1:0] {
        OP_NONE,
        OP_START,
        OP_STOP,
        OP_BIT
    } tmr_op_e;

endpackage

// File: rtl/i2c_tmr_sync.sv
// Multi-flop resynchronizer for asynchronous pad inputs.
// Assumes: STAGES >= 1; the reset value is the idle level of the lines.
module i2c_tmr_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stage_q;

            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= RST_VAL;
                else        stage_q <= din;
            end

            assign dout = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stage_q;

            // Shift chain: stage 0 captures the pad, the top stage feeds logic.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= {STAGES{RST_VAL}};
                else        stage_q <= {stage_q[STAGES-2:0], din};
            end

            assign dout = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/i2c_tmr_interval.sv
// Down-counter for one timed interval.
// After a load of N, expired reads 1 once max(N,1)-1 further edges have passed,
// so a state that leaves on expired lasts exactly max(N,1) cycles.
// Assumes: load and expiry are sampled by the same clocked sequencer.
module i2c_tmr_interval #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Load (zero is treated as one) or count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - ONE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/i2c_bus_timer.sv
// Two-wire bus timing and condition generator.
// Runs one START, STOP or bit-slot request at a time, driving open-drain
// pull-down enables for the clock and data lines with programmable periods
// and hold times, all counted in system clock cycles.
// Assumes: cfg_* are stable while busy; cfg_scl_div >= 2; bit and STOP
// requests are issued only while the clock line is held low by this block.
module i2c_bus_timer
    import i2c_tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_scl_div,
    input  logic [CNT_W-1:0] cfg_start_hold,
    input  logic [CNT_W-1:0] cfg_stop_setup,
    input  logic [CNT_W-1:0] cfg_data_hold,
    input  logic             req_start,
    input  logic             req_stop,
    input  logic             req_bit,
    input  logic             bit_val,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             rx_bit,
    output logic             done,
    output logic             busy
);

    // Low and high halves of the bus clock period.
    logic [CNT_W-1:0] half_lo;
    logic [CNT_W-1:0] half_hi;
    assign half_lo = cfg_scl_div >> 1;
    assign half_hi = cfg_scl_div - half_lo;

    // Resynchronized pad levels.
    logic [1:0] pads_s;
    logic       scl_s;
    logic       sda_s;

    i2c_tmr_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_in, sda_in}),
        .dout  (pads_s)
    );

    assign scl_s = pads_s[1];
    assign sda_s = pads_s[0];

    // Registered state.
    tmr_state_e state_q, state_n;
    tmr_op_e    op_q, op_n;
    logic       scl_low_q, scl_low_n;
    logic       sda_low_q, sda_low_n;
    logic       rx_q, rx_n;
    logic       done_q, done_n;

    // Interval counter shared by every timed phase.
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_expired;

    i2c_tmr_interval #(
        .CNT_W (CNT_W)
    ) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    // Next-state logic: request acceptance and phase sequencing.
    always_comb begin
        state_n   = state_q;
        op_n      = op_q;
        scl_low_n = scl_low_q;
        sda_low_n = sda_low_q;
        rx_n      = rx_q;
        done_n    = 1'b0;
        cnt_load  = 1'b0;
        cnt_val   = '0;

        unique case (state_q)
            ST_IDLE: begin
                if (req_start) begin
                    op_n      = OP_START;
                    sda_low_n = 1'b0;
                    cnt_load  = 1'b1;
                    cnt_val   = half_lo;
                    state_n   = ST_LOW;
                end else if (req_stop) begin
                    op_n      = OP_STOP;
                    sda_low_n = 1'b1;
                    cnt_load  = 1'b1;
                    cnt_val   = half_lo;
                    state_n   = ST_LOW;
                end else if (req_bit) begin
                    op_n      = OP_BIT;
                    sda_low_n = !bit_val;
                    cnt_load  = 1'b1;
                    cnt_val   = half_lo;
                    state_n   = ST_LOW;
                end
            end
            ST_LOW: begin
                if (cnt_expired) begin
                    scl_low_n = 1'b0;
                    state_n   = ST_RISE;
                end
            end
            ST_RISE: begin
                if (scl_s) begin
                    cnt_load = 1'b1;
                    cnt_val  = (op_q == OP_STOP) ? cfg_stop_setup : half_hi;
                    state_n  = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (cnt_expired) begin
                    cnt_load = 1'b1;
                    unique case (op_q)
                        OP_START: begin
                            sda_low_n = 1'b1;
                            cnt_val   = cfg_start_hold;
                            state_n   = ST_MID;
                        end
                        OP_STOP: begin
                            sda_low_n = 1'b0;
                            cnt_val   = half_hi;
                            state_n   = ST_TAIL;
                        end
                        default: begin
                            rx_n      = sda_s;
                            scl_low_n = 1'b1;
                            cnt_val   = cfg_data_hold;
                            state_n   = ST_TAIL;
                        end
                    endcase
                end
            end
            ST_MID: begin
                if (cnt_expired) begin
                    scl_low_n = 1'b1;
                    cnt_load  = 1'b1;
                    cnt_val   = cfg_data_hold;
                    state_n   = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (cnt_expired) begin
                    done_n  = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State and line-driver registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_NONE;
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
            rx_q      <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q   <= state_n;
            op_q      <= op_n;
            scl_low_q <= scl_low_n;
            sda_low_q <= sda_low_n;
            rx_q      <= rx_n;
            done_q    <= done_n;
        end
    end

    assign scl_drive_low = scl_low_q;
    assign sda_drive_low = sda_low_q;
    assign rx_bit        = rx_q;
    assign done          = done_q;
    assign busy          = (state_q != ST_IDLE);

    // R7: the completion pulse never lasts two cycles.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7: completion coincides with the return to idle.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));

    // R8: the request kind cannot change while one is in progress.
    p_op_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(op_q));

    // R10: with the clock released, the data line moves only as a START or STOP edge.
    p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_low_q) && !$past(scl_low_q) && !scl_low_q)
        |-> ((op_q == OP_START && sda_low_q) || (op_q == OP_STOP && !sda_low_q)));

    // R4: during the data hold the clock stays low and the data line is frozen.
    p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && op_q != OP_STOP) |-> (scl_low_q && $stable(sda_low_q)));

    // R2: a finished START leaves both lines pulled low.
    p_start_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_START) |-> (scl_low_q && sda_low_q));

    // R3: a finished STOP leaves both lines released.
    p_stop_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_STOP) |-> (!scl_low_q && !sda_low_q));

endmodule

// File: tb/tb_i2c_bus_timer.sv
// Self-checking bench for the two-wire bus timing generator.
// Models open-drain lines, a clock-stretching slave and a slave that drives data.
module tb_i2c_bus_timer;

    localparam int CW = 16;
    localparam int SS = 2;
    localparam int NV = 4;

    // Stimulus table: divider, start hold, stop setup, data hold, stretch, 3 data bits.
    localparam int V_DIV [NV] = '{20, 40, 25, 125};
    localparam int V_STA [NV] = '{8, 24, 5, 30};
    localparam int V_STO [NV] = '{9, 24, 7, 30};
    localparam int V_DAT [NV] = '{3, 10, 2, 4};
    localparam int V_STR [NV] = '{0, 0, 6, 10};
    localparam logic [2:0] V_BITS [NV] = '{3'b101, 3'b010, 3'b110, 3'b011};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic [CW-1:0] cfg_div = 16'd20, cfg_sta = 16'd8, cfg_sto = 16'd9, cfg_dat = 16'd3;
    logic req_start = 1'b0, req_stop = 1'b0, req_bit = 1'b0, bit_val = 1'b0;
    logic slave_hold = 1'b0, slave_sda = 1'b0;
    logic scl_drive_low, sda_drive_low, rx_bit, done, busy;

    wire scl_line = !(scl_drive_low | slave_hold);
    wire sda_line = !(sda_drive_low | slave_sda);

    i2c_bus_timer #(.CNT_W(CW), .SYNC_STAGES(SS)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_scl_div    (cfg_div),
        .cfg_start_hold (cfg_sta),
        .cfg_stop_setup (cfg_sto),
        .cfg_data_hold  (cfg_dat),
        .req_start      (req_start),
        .req_stop       (req_stop),
        .req_bit        (req_bit),
        .bit_val        (bit_val),
        .scl_in         (scl_line),
        .sda_in         (sda_line),
        .scl_drive_low  (scl_drive_low),
        .sda_drive_low  (sda_drive_low),
        .rx_bit         (rx_bit),
        .done           (done),
        .busy           (busy)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int t_line_hi = 0, t_scl_pull = 0, t_scl_rel = 0;
    int t_sda_pull = 0, t_sda_rel = 0, t_sda_chg = 0, t_done = 0, t_req = 0;
    int stretch_k = 0, hold_ctr = 0;
    logic line_prev = 1'b1, scl_prev = 1'b0, sda_prev = 1'b0, line_at_pull = 1'b0;

    // Event monitor and stretching slave, evaluated at falling clock edges.
    always @(negedge clk) begin
        logic line_now;
        cyc++;
        line_now = scl_line;
        if (line_now && !line_prev) t_line_hi = cyc;
        line_prev = line_now;
        if (scl_drive_low && !scl_prev) t_scl_pull = cyc;
        if (!scl_drive_low && scl_prev) t_scl_rel = cyc;
        scl_prev = scl_drive_low;
        if (sda_drive_low != sda_prev) begin
            t_sda_chg = cyc;
            if (sda_drive_low) begin
                t_sda_pull   = cyc;
                line_at_pull = line_now;
            end else begin
                t_sda_rel = cyc;
            end
        end
        sda_prev = sda_drive_low;
        if (done) t_done = cyc;
        if (stretch_k > 0) begin
            if (scl_drive_low) begin
                slave_hold = 1'b1;
                hold_ctr   = 0;
            end else if (slave_hold) begin
                hold_ctr++;
                if (hold_ctr >= stretch_k) begin
                    slave_hold = 1'b0;
                    t_line_hi  = cyc;
                    line_prev  = 1'b1;
                end
            end
        end else begin
            slave_hold = 1'b0;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic issue(input bit s, input bit p, input bit b, input bit bv);
        @(posedge clk); #2;
        req_start = s; req_stop = p; req_bit = b; bit_val = bv;
        t_req = cyc + 1;
        @(posedge clk); #2;
        req_start = 1'b0; req_stop = 1'b0; req_bit = 1'b0;
    endtask

    // R7: wait for done, then check the pulse shape.
    task automatic wait_done();
        int n = 0;
        bit seen = 1'b0;
        while (!seen && n < 20000) begin
            @(negedge clk); #1;
            n++;
            if (done) seen = 1'b1;
        end
        if (!seen) begin
            chk("R7 done timeout", 0, 1);
        end else begin
            chk("R7 busy low with done", int'(busy), 0);
            @(negedge clk); #1;
            chk("R7 done one cycle", int'(done), 0);
        end
    endtask

    function automatic int lo_of(input int d); return d / 2; endfunction
    function automatic int hi_of(input int d); return d - d / 2; endfunction

    task automatic do_start();
        issue(1'b1, 1'b0, 1'b0, 1'b0);
        wait_done();
        chk("R2 start hold", t_scl_pull - t_sda_pull, (cfg_sta == 0) ? 1 : int'(cfg_sta));
        chk("R2 line high at sda fall", int'(line_at_pull), 1);
        chk("R4 hold after start", t_done - t_scl_pull, (cfg_dat == 0) ? 1 : int'(cfg_dat));
    endtask

    task automatic do_bit(input bit bv, input bit pull);
        slave_sda = pull;
        issue(1'b0, 1'b0, 1'b1, bv);
        wait_done();
        chk("R5 low half", t_scl_rel - t_req, lo_of(cfg_div) + 1);
        chk("R5 R6 high phase", t_scl_pull - t_line_hi, hi_of(cfg_div) + SS + 1);
        if (stretch_k > 0) chk("R6 stretch length", t_line_hi - t_scl_rel, stretch_k - 1);
        chk("R4 data hold", t_done - t_scl_pull, (cfg_dat == 0) ? 1 : int'(cfg_dat));
        chk("R10 sda set at accept", int'(t_sda_chg <= t_req + 1), 1);
        chk("R10 sda level", int'(sda_drive_low), int'(!bv));
        chk("R9 rx bit", int'(rx_bit), int'(bv && !pull));
        slave_sda = 1'b0;
    endtask

    task automatic do_stop();
        issue(1'b0, 1'b1, 1'b0, 1'b0);
        wait_done();
        chk("R3 stop setup", t_sda_rel - t_line_hi, int'(cfg_sto) + SS + 1);
        chk("R3 bus free", t_done - t_sda_rel, hi_of(cfg_div));
        chk("R3 lines released", int'(scl_drive_low) + int'(sda_drive_low), 0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 scl released", int'(scl_drive_low), 0);
        chk("R1 sda released", int'(sda_drive_low), 0);
        chk("R1 done low", int'(done), 0);
        chk("R1 busy low", int'(busy), 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        // Table walk: full transactions with different timings and stretching.
        for (int i = 0; i < NV; i++) begin
            cfg_div = CW'(V_DIV[i]);
            cfg_sta = CW'(V_STA[i]);
            cfg_sto = CW'(V_STO[i]);
            cfg_dat = CW'(V_DAT[i]);
            stretch_k = V_STR[i];
            do_start();
            for (int k = 2; k >= 0; k--) do_bit(V_BITS[i][k], 1'b0);
            do_stop();
        end
        stretch_k = 0;
        cfg_div = 16'd20; cfg_sta = 16'd8; cfg_sto = 16'd9; cfg_dat = 16'd3;

        // R9: slave drives data low in a released slot.
        do_start();
        do_bit(1'b1, 1'b1);
        do_bit(1'b1, 1'b0);

        // R8: START beats a bit request (repeated START).
        issue(1'b1, 1'b0, 1'b1, 1'b1);
        wait_done();
        chk("R8 start wins sda", int'(sda_drive_low), 1);
        chk("R8 start wins scl", int'(scl_drive_low), 1);
        chk("R2 repeated start edge", int'(line_at_pull), 1);
        chk("R2 repeated start hold", t_scl_pull - t_sda_pull, int'(cfg_sta));

        // R8: STOP beats a bit request.
        do_bit(1'b1, 1'b0);
        issue(1'b0, 1'b1, 1'b1, 1'b1);
        wait_done();
        chk("R8 stop wins", int'(scl_drive_low) + int'(sda_drive_low), 0);

        // R8: a STOP request while busy is ignored.
        do_start();
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #2 req_stop = 1'b1;
        @(posedge clk); #2 req_stop = 1'b0;
        wait_done();
        chk("R8 ignored stop sda", int'(sda_drive_low), 1);
        chk("R8 ignored stop scl", int'(scl_drive_low), 1);
        begin
            int busy_seen = 0;
            for (int j = 0; j < 60; j++) begin
                @(negedge clk); #1;
                if (busy) busy_seen++;
            end
            chk("R8 no extra request", busy_seen, 0);
        end
        do_stop();

        // R11: zero counts act as one.
        cfg_sta = 16'd0; cfg_dat = 16'd0;
        do_start();
        do_bit(1'b0, 1'b0);
        do_stop();
        cfg_sta = 16'd8; cfg_dat = 16'd3;

        // R1: reset in the middle of a bit slot.
        do_start();
        issue(1'b0, 1'b0, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 mid reset scl", int'(scl_drive_low), 0);
        chk("R1 mid reset sda", int'(sda_drive_low), 0);
        chk("R1 mid reset busy", int'(busy), 0);
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (4) @(posedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule